// File: doc/BRIEF.md
# Three-Channel Event Timer

This block holds three independent 32-bit timers behind a small register bus. Each timer has a live counter, a reload value and two compare values. The counter steps up or down on every clock, or only on the cycles where its tick-enable input is high. A step past the end of the range reloads the counter and raises an overflow event. A step that lands on either compare value raises a compare event. All nine event bits collect in one sticky status register. A mask register and a per-timer interrupt-enable bit gate the events onto three interrupt lines.

Software uses it in two ways. For periodic ticks it loads the counter and the reload value with all-ones minus (P − 1) and counts upward, which gives one overflow every P steps. For one-shot events it reads the running count and writes that count plus a delta into the first compare register. Reads return live values in the same cycle. Writes take effect at the next clock edge.

Top module: `tmr_triple`

## Requirements
- R1: After a synchronous active-high reset every register reads zero and all three `irq` lines are low.
- R2: The bus is word addressed (`bus_addr[1:0]` ignored). Timer n (0..2) occupies 0x10·n + {0x0 counter, 0x4 reload, 0x8 compare 1, 0xC compare 2}. Control is at 0x30 (12 bits), status at 0x34 (9 bits) and mask at 0x38 (9 bits). Unused upper bits read zero. 0x3C and any address with `bus_addr[7:6]` nonzero read zero and ignore writes.
- R3: Control bit 9+n set selects up-counting for timer n. A step adds one. A step from 0xFFFFFFFF loads the reload value instead and sets status bit 3n+2 (overflow).
- R4: Control bit 9+n clear selects down-counting. A step subtracts one. A step from zero loads the reload value and sets status bit 3n+2.
- R5: Up-counting with counter and reload both set to 0xFFFFFFFF − (P − 1) makes the first overflow event land on the P-th step.
- R6: A step whose resulting count equals compare 1 sets status bit 3n. A step whose resulting count equals compare 2 sets status bit 3n+1.
- R7: With control bit 3n (enable) clear, timer n holds its count and raises no events.
- R8: Control bit 3n+1 set makes timer n step only in cycles where `tick_en[n]` is high. When the bit is clear, the timer steps on every clock.
- R9: Status bits stay set until software changes them. A write to 0x34 replaces the status with the written value. An event in the same cycle as that write still sets its bit.
- R10: `irq[n]` is high exactly when control bit 3n+2 (interrupt enable) is set and at least one of status bits 3n..3n+2 is set together with the matching mask bit. It follows the registers with no added delay.
- R11: A bus write to a counter loads the written value at the next edge. It overrides that cycle's step, and that cycle raises no event for the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_en | input | 3 | Per-timer step qualifier used in external-tick mode |
| irq | output | 3 | Per-timer interrupt lines |

## Verification
The assertions assume that reset is held at the start of the run. They also assume that `bus_addr`, `bus_we` and `tick_en` are always known values, because the hold, wrap and tick-gating properties exempt only cycles that carry a counter write. The stimulus keeps to this. It holds reset for the first cycles and drives only word-aligned addresses from a fixed-seed generator. It also picks counter and compare values near the wrap points and near the live count, so that overflow and compare events occur often alongside random control, mask and status writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int N_TMR  = 3;
    localparam int EV_W   = 3;
    localparam int ST_W   = N_TMR * EV_W;
    localparam int CT_W   = N_TMR * 4;
    localparam int AW     = 8;

    localparam logic [1:0] BLK_SHARED = 2'd3;
    localparam logic [1:0] SUB_CTRL   = 2'd0;
    localparam logic [1:0] SUB_STAT   = 2'd1;
    localparam logic [1:0] SUB_MASK   = 2'd2;

    typedef enum logic [1:0] {
        R_CNT  = 2'd0,
        R_RLD  = 2'd1,
        R_CMP1 = 2'd2,
        R_CMP2 = 2'd3
    } tmr_reg_e;

    // bit 0 = compare 1, bit 1 = compare 2, bit 2 = overflow
    typedef struct packed {
        logic ovf;
        logic cmp2;
        logic cmp1;
    } tmr_ev_t;

    typedef struct packed {
        logic en;
        logic ext;
        logic ien;
        logic up;
    } tmr_cfg_t;

    function automatic tmr_cfg_t cfg_of(input logic [CT_W-1:0] c, input int n);
        tmr_cfg_t r;
        r.en  = c[3*n];
        r.ext = c[3*n+1];
        r.ien = c[3*n+2];
        r.up  = c[3*N_TMR+n];
        return r;
    endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          count_up,
    input  logic          wr_en,
    input  tmr_reg_e      wr_reg,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] rld_o,
    output logic [CW-1:0] cmp1_o,
    output logic [CW-1:0] cmp2_o,
    output tmr_ev_t       ev_o
);

    localparam logic [CW-1:0] ALL_ONES = '1;

    logic [CW-1:0] cnt_q, rld_q, cmp1_q, cmp2_q;
    logic [CW-1:0] cnt_nx;
    logic          at_end;
    logic          load_cnt;

    always_comb begin
        if (count_up) begin
            at_end = (cnt_q == ALL_ONES);
            cnt_nx = at_end ? rld_q : cnt_q + CW'(1);
        end else begin
            at_end = (cnt_q == '0);
            cnt_nx = at_end ? rld_q : cnt_q - CW'(1);
        end
        load_cnt = wr_en && (wr_reg == R_CNT);
        ev_o = '0;
        if (run && !load_cnt) begin
            ev_o.ovf  = at_end;
            ev_o.cmp1 = (cnt_nx == cmp1_q);
            ev_o.cmp2 = (cnt_nx == cmp2_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            rld_q  <= '0;
            cmp1_q <= '0;
            cmp2_q <= '0;
        end else begin
            if (load_cnt)
                cnt_q <= wr_data;
            else if (run)
                cnt_q <= cnt_nx;
            if (wr_en && wr_reg == R_RLD)  rld_q  <= wr_data;
            if (wr_en && wr_reg == R_CMP1) cmp1_q <= wr_data;
            if (wr_en && wr_reg == R_CMP2) cmp2_q <= wr_data;
        end
    end

    assign cnt_o  = cnt_q;
    assign rld_o  = rld_q;
    assign cmp1_o = cmp1_q;
    assign cmp2_o = cmp2_q;

endmodule

// File: rtl/tmr_evt_ctl.sv
module tmr_evt_ctl
    import tmr_pkg::*;
#(
    parameter int NT = 3,
    parameter int CW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_ctrl,
    input  logic            wr_stat,
    input  logic            wr_mask,
    input  logic [CW-1:0]   wr_data,
    input  logic [3*NT-1:0] ev_in,
    output logic [4*NT-1:0] ctrl_o,
    output logic [3*NT-1:0] stat_o,
    output logic [3*NT-1:0] mask_o,
    output logic [NT-1:0]   irq_o
);

    localparam int CTW = 4 * NT;
    localparam int STW = 3 * NT;

    logic [CTW-1:0] ctrl_q;
    logic [STW-1:0] stat_q, mask_q;
    logic [STW-1:0] stat_base;

    // a same-cycle event is ORed after the replacing write, so it wins
    assign stat_base = wr_stat ? wr_data[STW-1:0] : stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= stat_base | ev_in;
            if (wr_ctrl) ctrl_q <= wr_data[CTW-1:0];
            if (wr_mask) mask_q <= wr_data[STW-1:0];
        end
    end

    for (genvar n = 0; n < NT; n++) begin : g_irq
        assign irq_o[n] = ctrl_q[3*n+2] & (|(stat_q[3*n +: 3] & mask_q[3*n +: 3]));
    end

    assign ctrl_o = ctrl_q;
    assign stat_o = stat_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/tmr_triple.sv
module tmr_triple
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [7:0]    bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    input  logic [2:0]    tick_en,
    output logic [2:0]    irq
);

    logic [1:0] blk, sub;
    logic       in_range;

    assign in_range = (bus_addr[7:6] == 2'b00);
    assign blk      = bus_addr[5:4];
    assign sub      = bus_addr[3:2];

    logic [CT_W-1:0]       ctrl_q;
    logic [ST_W-1:0]       stat_q, mask_q;
    logic [ST_W-1:0]       ev_all;
    logic [N_TMR*CW-1:0]   cnt_flat;
    logic [CW-1:0]         cnt_a  [N_TMR];
    logic [CW-1:0]         rld_a  [N_TMR];
    logic [CW-1:0]         cmp1_a [N_TMR];
    logic [CW-1:0]         cmp2_a [N_TMR];

    for (genvar n = 0; n < N_TMR; n++) begin : g_tmr
        tmr_cfg_t cfg;
        tmr_ev_t  ev;
        logic     run, wr_sel;

        assign cfg    = cfg_of(ctrl_q, n);
        assign run    = cfg.en && (cfg.ext ? tick_en[n] : 1'b1);
        assign wr_sel = bus_we && in_range && (blk == 2'(n));

        tmr_channel #(.CW(CW)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .run      (run),
            .count_up (cfg.up),
            .wr_en    (wr_sel),
            .wr_reg   (tmr_reg_e'(sub)),
            .wr_data  (bus_wdata),
            .cnt_o    (cnt_a[n]),
            .rld_o    (rld_a[n]),
            .cmp1_o   (cmp1_a[n]),
            .cmp2_o   (cmp2_a[n]),
            .ev_o     (ev)
        );

        assign ev_all[EV_W*n +: EV_W] = ev;
        assign cnt_flat[CW*n +: CW]   = cnt_a[n];
    end

    logic shared_wr;
    assign shared_wr = bus_we && in_range && (blk == BLK_SHARED);

    tmr_evt_ctl #(.NT(N_TMR), .CW(CW)) u_evt (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (shared_wr && sub == SUB_CTRL),
        .wr_stat (shared_wr && sub == SUB_STAT),
        .wr_mask (shared_wr && sub == SUB_MASK),
        .wr_data (bus_wdata),
        .ev_in   (ev_all),
        .ctrl_o  (ctrl_q),
        .stat_o  (stat_q),
        .mask_o  (mask_q),
        .irq_o   (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (in_range) begin
            if (blk == BLK_SHARED) begin
                case (sub)
                    SUB_CTRL: bus_rdata = CW'(ctrl_q);
                    SUB_STAT: bus_rdata = CW'(stat_q);
                    SUB_MASK: bus_rdata = CW'(mask_q);
                    default:  bus_rdata = '0;
                endcase
            end else begin
                for (int n = 0; n < N_TMR; n++) begin
                    if (blk == 2'(n)) begin
                        case (tmr_reg_e'(sub))
                            R_CNT:  bus_rdata = cnt_a[n];
                            R_RLD:  bus_rdata = rld_a[n];
                            R_CMP1: bus_rdata = cmp1_a[n];
                            R_CMP2: bus_rdata = cmp2_a[n];
                            default: bus_rdata = '0;
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tmr_triple_chk.sv
module tmr_triple_chk
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_we,
    input logic [7:0]          bus_addr,
    input logic [2:0]          tick_en,
    input logic [CT_W-1:0]     ctrl,
    input logic [ST_W-1:0]     stat,
    input logic [N_TMR*CW-1:0] cnt,
    input logic [2:0]          irq
);

    localparam logic [CW-1:0] ALL_ONES = '1;

    logic stat_wr;
    assign stat_wr = bus_we && bus_addr[7:6] == 2'b00 &&
                     bus_addr[5:4] == BLK_SHARED && bus_addr[3:2] == SUB_STAT;

    // R1: reset leaves the block quiet
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (irq == '0 && stat == '0 && ctrl == '0));

    // R9: a set status bit survives every cycle without a status write
    assert_status_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((stat & $past(stat)) == $past(stat)));

    for (genvar n = 0; n < N_TMR; n++) begin : g_chk
        logic cnt_wr;
        assign cnt_wr = bus_we && bus_addr[7:6] == 2'b00 &&
                        bus_addr[5:4] == 2'(n) && bus_addr[3:2] == 2'b00;

        assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (rst)
            (!ctrl[3*n] && !cnt_wr) |=> $stable(cnt[CW*n +: CW]));

        assert_ext_tick_gate_R8: assert property (@(posedge clk) disable iff (rst)
            (ctrl[3*n] && ctrl[3*n+1] && !tick_en[n] && !cnt_wr) |=> $stable(cnt[CW*n +: CW]));

        assert_up_wrap_ovf_R3: assert property (@(posedge clk) disable iff (rst)
            (ctrl[3*n] && !ctrl[3*n+1] && ctrl[3*N_TMR+n] && !cnt_wr &&
             cnt[CW*n +: CW] == ALL_ONES) |=> stat[3*n+2]);

        assert_down_wrap_ovf_R4: assert property (@(posedge clk) disable iff (rst)
            (ctrl[3*n] && !ctrl[3*n+1] && !ctrl[3*N_TMR+n] && !cnt_wr &&
             cnt[CW*n +: CW] == '0) |=> stat[3*n+2]);

        assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
            irq[n] |-> (ctrl[3*n+2] && stat[3*n +: 3] != '0));
    end

endmodule

bind tmr_triple tmr_triple_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .tick_en  (tick_en),
    .ctrl     (ctrl_q),
    .stat     (stat_q),
    .cnt      (cnt_flat),
    .irq      (irq)
);

// File: tb/tb_tmr_triple.sv
module tb_tmr_triple;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  tick = '0;
    logic [2:0]  irq;

    always #4 clk = ~clk;

    tmr_triple #(.CW(32)) dut (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .tick_en(tick), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state, built from the requirements
    logic [31:0] m_cnt [3];
    logic [31:0] m_rld [3];
    logic [31:0] m_c1  [3];
    logic [31:0] m_c2  [3];
    logic [11:0] m_ctrl;
    logic [8:0]  m_st, m_mk;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a[7:6] != 2'b00) return 32'h0;
        if (a[5:4] == 2'd3) begin
            case (a[3:2])
                2'd0: return {20'h0, m_ctrl};
                2'd1: return {23'h0, m_st};
                2'd2: return {23'h0, m_mk};
                default: return 32'h0;
            endcase
        end
        case (a[3:2])
            2'd0: return m_cnt[a[5:4]];
            2'd1: return m_rld[a[5:4]];
            2'd2: return m_c1[a[5:4]];
            default: return m_c2[a[5:4]];
        endcase
    endfunction

    function automatic logic [2:0] m_irq();
        logic [2:0] r;
        for (int n = 0; n < 3; n++)
            r[n] = m_ctrl[3*n+2] && ((m_st[3*n +: 3] & m_mk[3*n +: 3]) != 3'b000);
        return r;
    endfunction

    task automatic model_reset();
        for (int n = 0; n < 3; n++) begin
            m_cnt[n] = '0; m_rld[n] = '0; m_c1[n] = '0; m_c2[n] = '0;
        end
        m_ctrl = '0; m_st = '0; m_mk = '0;
    endtask

    task automatic model_edge(input logic w, input logic [7:0] a,
                              input logic [31:0] d, input logic [2:0] t);
        logic [8:0] ev;
        logic       ok;
        ev = '0;
        ok = (a[7:6] == 2'b00);
        for (int n = 0; n < 3; n++) begin
            logic        run, up, wrap, hit;
            logic [31:0] nv;
            hit  = w && ok && (a[5:4] == 2'(n));
            run  = m_ctrl[3*n] && (m_ctrl[3*n+1] ? t[n] : 1'b1);
            up   = m_ctrl[9+n];
            wrap = up ? (m_cnt[n] == 32'hFFFF_FFFF) : (m_cnt[n] == 32'h0);
            nv   = wrap ? m_rld[n] : (up ? m_cnt[n] + 32'd1 : m_cnt[n] - 32'd1);
            if (hit && a[3:2] == 2'd0) m_cnt[n] = d;
            else if (run) begin
                m_cnt[n]  = nv;
                ev[3*n]   = (nv == m_c1[n]);
                ev[3*n+1] = (nv == m_c2[n]);
                ev[3*n+2] = wrap;
            end
            if (hit && a[3:2] == 2'd1) m_rld[n] = d;
            if (hit && a[3:2] == 2'd2) m_c1[n]  = d;
            if (hit && a[3:2] == 2'd3) m_c2[n]  = d;
        end
        if (w && ok && a[5:4] == 2'd3 && a[3:2] == 2'd0) m_ctrl = d[11:0];
        if (w && ok && a[5:4] == 2'd3 && a[3:2] == 2'd2) m_mk = d[8:0];
        if (w && ok && a[5:4] == 2'd3 && a[3:2] == 2'd1) m_st = d[8:0];
        m_st = m_st | ev;
    endtask

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic [2:0] t, input string tag, output logic [31:0] got);
        logic [2:0] ei;
        @(negedge clk);
        ei = m_irq();
        check(irq == ei, "R10 irq lines", {29'h0, irq}, {29'h0, ei});
        we = w; addr = a; wdata = d; tick = t;
        #1;
        got = rdata;
        if (!w) check(rdata == m_read(a), tag, rdata, m_read(a));
        @(posedge clk);
        model_edge(w, a, d, t);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] g;
        cyc(1'b1, a, d, 3'b000, "", g);
    endtask

    task automatic rd(input logic [7:0] a, input string tag, output logic [31:0] g);
        cyc(1'b0, a, 32'h0, 3'b000, tag, g);
    endtask

    task automatic idle(input int n, input logic [2:0] t);
        logic [31:0] g;
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h30, 32'h0, t, "R2 idle read", g);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1: actual hung expected finished");
            summary();
            $finish;
        end
    end

    function automatic logic [31:0] rand_val(input int n);
        case ($urandom % 4)
            0: return 32'hFFFF_FFFF - ($urandom % 5);
            1: return $urandom % 5;
            2: return m_cnt[n] + ($urandom % 6);
            default: return $urandom;
        endcase
    endfunction

    initial begin
        logic [31:0] v, v2;
        int          first;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every mapped register zero, lines quiet
        for (int a = 0; a < 16; a++) begin
            rd(8'(a*4), "R1 reset value", v);
            check(v == 32'h0, "R1 reset zero", v, 32'h0);
        end
        check(irq == 3'b000, "R1 irq after reset", {29'h0, irq}, 32'h0);

        // R2: map, widths and holes
        wr(8'h14, 32'hA5A5_1234);
        rd(8'h14, "R2 reload t1", v);
        check(v == 32'hA5A5_1234, "R2 reload readback", v, 32'hA5A5_1234);
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h38, "R2 mask width", v);
        check(v == 32'h1FF, "R2 mask width", v, 32'h1FF);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h3C, "R2 hole", v);
        check(v == 32'h0, "R2 hole reads zero", v, 32'h0);
        wr(8'h80, 32'h1234_5678);
        rd(8'h80, "R2 out of range", v);
        check(v == 32'h0, "R2 out of range", v, 32'h0);
        wr(8'h38, 32'h0);

        // R3: up count and wrap with reload
        wr(8'h00, 32'hFFFF_FFFE);
        wr(8'h04, 32'h0000_0007);
        wr(8'h34, 32'h0);
        wr(8'h30, 32'h0000_0201);
        idle(2, 3'b000);
        wr(8'h30, 32'h0);
        rd(8'h00, "R3 count after wrap", v);
        check(v == 32'h8, "R3 reload then step", v, 32'h8);
        rd(8'h34, "R3 status", v);
        check(v[2] == 1'b1, "R3 overflow bit", v, 32'h4);

        // R4: down count and underflow
        wr(8'h34, 32'h0);
        wr(8'h00, 32'h2);
        wr(8'h04, 32'h40);
        wr(8'h30, 32'h0000_0001);
        idle(3, 3'b000);
        wr(8'h30, 32'h0);
        rd(8'h00, "R4 count after underflow", v);
        check(v == 32'h3F, "R4 reload then step", v, 32'h3F);
        rd(8'h34, "R4 status", v);
        check(v[2] == 1'b1, "R4 underflow bit", v, 32'h4);

        // R7: disabled timer holds
        rd(8'h00, "R7 held count", v);
        idle(4, 3'b111);
        rd(8'h00, "R7 held count later", v2);
        check(v == v2, "R7 hold when disabled", v2, v);

        // R8: external tick qualifier on timer 1, down count
        wr(8'h10, 32'd1000);
        wr(8'h30, 32'h0000_0018);
        idle(6, 3'b101);
        idle(4, 3'b010);
        wr(8'h30, 32'h0);
        rd(8'h10, "R8 ticked count", v);
        check(v == 32'd996, "R8 steps only on tick", v, 32'd996);

        // R5 and R10: periodic overflow on timer 1 with P = 7
        wr(8'h34, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF - 32'd6);
        wr(8'h14, 32'hFFFF_FFFF - 32'd6);
        wr(8'h38, 32'h20);
        wr(8'h30, 32'h0000_0428);
        first = 0;
        for (int i = 1; i <= 12; i++) begin
            idle(1, 3'b000);
            #1;
            if (first == 0 && irq[1]) first = i;
        end
        check(first == 7, "R5 overflow period", 32'(first), 32'd7);
        wr(8'h30, 32'h0000_0408);
        #1;
        check(irq[1] == 1'b0, "R10 enable gates line", {31'h0, irq[1]}, 32'h0);
        wr(8'h30, 32'h0);
        wr(8'h38, 32'h0);

        // R6: compare events on timer 2, up count
        wr(8'h34, 32'h0);
        wr(8'h20, 32'd100);
        wr(8'h28, 32'd110);
        wr(8'h2C, 32'd105);
        wr(8'h30, 32'h0000_0840);
        idle(5, 3'b000);
        rd(8'h34, "R6 status mid", v);
        check(v[7:6] == 2'b10, "R6 compare 2 only", {30'h0, v[7:6]}, 32'h2);
        idle(4, 3'b000);
        rd(8'h34, "R6 status late", v);
        check(v[7:6] == 2'b11, "R6 both compares", {30'h0, v[7:6]}, 32'h3);

        // R11 and R9: counter write, then clear racing an event
        wr(8'h2C, 32'h0);
        wr(8'h28, 32'd202);
        wr(8'h20, 32'd200);
        rd(8'h20, "R11 counter write", v);
        check(v == 32'd200, "R11 written count", v, 32'd200);
        wr(8'h34, 32'h0);
        rd(8'h34, "R9 event beats clear", v);
        check(v[6] == 1'b1, "R9 event wins", v, 32'h40);
        wr(8'h30, 32'h0);
        wr(8'h34, 32'h0);
        rd(8'h34, "R9 clear", v);
        check(v == 32'h0, "R9 write replaces", v, 32'h0);
        wr(8'h20, 32'd202);
        rd(8'h34, "R11 no event on write", v);
        check(v == 32'h0, "R11 write raises nothing", v, 32'h0);

        // random mix against the reference
        for (int k = 0; k < 4000; k++) begin
            int          op, n, s;
            logic [2:0]  tk;
            logic [31:0] g;
            op = $urandom % 12;
            tk = 3'($urandom);
            n  = $urandom % 3;
            s  = $urandom % 4;
            if (op < 3)
                cyc(1'b1, 8'(n*16 + s*4), rand_val(n), tk, "", g);
            else if (op == 3)
                cyc(1'b1, 8'h30, $urandom, tk, "", g);
            else if (op == 4)
                cyc(1'b1, 8'h34, ($urandom % 2) ? 32'h0 : $urandom, tk, "", g);
            else if (op == 5)
                cyc(1'b1, 8'h38, $urandom, tk, "", g);
            else if (op == 6)
                cyc(1'b0, 8'h40 + 8'(($urandom % 48) * 4), 32'h0, tk, "R2 random unmapped", g);
            else
                cyc(1'b0, 8'(($urandom % 16) * 4), 32'h0, tk, "R2 R6 random read", g);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule